// File: doc/BRIEF.md
# Interval Timer and Time Clock Word

This block keeps two time counters that share one 64-bit register word and advance on the same tick strobe, which is nominally 1024 Hz. The first counter is a 19-bit interval timer that counts down and wraps around. Each time a tick brings it down to zero, it raises a sticky time-signal flag. The second counter is a 36-bit time clock that counts up and runs without stopping. Its low ten bits count ticks within one second, and its upper 26 bits count whole seconds.

Software reads the whole word at once. A single write loads both counters together. A separate clear input drops the time-signal flag. Generating the tick is outside this block; the tick arrives as a one-cycle strobe that is synchronous to the system clock.

Top module: `ivtc_word`

## Requirements
- R1: The word places the interval timer in bits 18:0 and the time clock in bits 63:28. Bits 27:19 always read zero.
- R2: After reset, both counters are zero and the time-signal flag is low.
- R3: On each tick without a write, the interval timer drops by one. In cycles with no tick and no write, neither counter changes.
- R4: A tick while the interval timer is zero wraps it to 0x7FFFF.
- R5: A tick that takes the interval timer from 1 to 0 sets the time-signal flag at the same clock edge on which the timer reaches zero.
- R6: The flag stays set until the clear input is asserted, and the clear takes effect on the next edge. If a set event and a clear fall in the same cycle, the flag ends up set.
- R7: Only a tick-driven step from 1 to 0 sets the flag. Loading zero and wrapping from zero both leave the flag unchanged.
- R8: On each tick without a write, the time clock rises by one. Its fraction field (bits 37:28) carries from 1023 into the seconds field (bits 63:38).
- R9: A tick while the time clock is all ones wraps it to zero.
- R10: A write loads the interval timer from data bits 18:0 and the time clock from data bits 63:28 on the next edge. Data bits 27:19 are ignored.
- R11: When a tick and a write fall in the same cycle, the written values are loaded and that tick is lost for both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1024 Hz tick strobe |
| wr_en | input | 1 | Load enable for both counters |
| wr_data | input | 64 | Word to load |
| ind_clr | input | 1 | Clears the time-signal flag |
| word_out | output | 64 | Packed timer and clock word |
| time_sig | output | 1 | Sticky time-signal flag |

## Verification
The bench steps the interval timer through 1 to 0 and then through the wrap from zero. A design that decodes zero as a level, instead of detecting the transition, would raise the flag again after a clear, or would raise it when zero is loaded. The bench drives a tick and a write in the same cycle; a design with the wrong priority would show a loaded value that is off by one. It also drives a set event and a clear in the same cycle; a design with the wrong priority would lose the event. Further cases cover the carry from the fraction field into the seconds field, the wrap of the time clock from all ones, and writes of all ones. These expose a missing carry, a clock that stalls at its maximum, and gap bits that hold written data.

// File: rtl/ivtc_pkg.sv
package ivtc_pkg;
   localparam int unsigned IVTC_WORD_W = 64;
   localparam int unsigned IVTC_TMR_W  = 19;
   localparam int unsigned IVTC_CLK_LSB = 28;
   localparam int unsigned IVTC_FRAC_W = 10;
   localparam int unsigned IVTC_SEC_W  = 26;

   typedef enum logic [1:0] {
      IVTC_HOLD = 2'd0,
      IVTC_STEP = 2'd1,
      IVTC_LOAD = 2'd2
   } ivtc_op_e;

   function automatic ivtc_op_e ivtc_decode(input logic tick, input logic load);
      if (load)      return IVTC_LOAD;
      else if (tick) return IVTC_STEP;
      else           return IVTC_HOLD;
   endfunction
endpackage

// File: rtl/ivtc_interval_timer.sv
module ivtc_interval_timer
   import ivtc_pkg::*;
#(
   parameter int unsigned TMR_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   input  logic             clr,
   output logic [TMR_W-1:0] cnt,
   output logic             ind
);
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   if (TMR_W < 2) begin : g_bad_width
      $error("ivtc_interval_timer: TMR_W must be at least 2");
   end

   ivtc_op_e   op;
   logic       set_ev;

   assign op     = ivtc_decode(tick, load);
   assign set_ev = (op == IVTC_STEP) && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case (op)
            IVTC_LOAD: cnt <= load_val;
            IVTC_STEP: cnt <= cnt - ONE;
            default:   cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       ind <= 1'b0;
      else if (set_ev)  ind <= 1'b1;
      else if (clr)     ind <= 1'b0;
   end

   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> (cnt == TMR_W'($past(cnt) - ONE)));
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
   assert_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == '0) |=> (cnt == '1));
   assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == ONE) |=> (ind && cnt == '0));
   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ind && !clr) |=> ind);
   assert_flag_only_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ind && !(tick && !load && cnt == ONE)) |=> !ind);
   assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/ivtc_time_clock.sv
module ivtc_time_clock
   import ivtc_pkg::*;
#(
   parameter int unsigned FRAC_W = 10,
   parameter int unsigned SEC_W  = 26,
   parameter bit          SPLIT  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    load,
   input  logic [FRAC_W+SEC_W-1:0] load_val,
   output logic [FRAC_W+SEC_W-1:0] cnt
);
   localparam int unsigned CLK_W = FRAC_W + SEC_W;

   if (FRAC_W < 1 || SEC_W < 1) begin : g_bad_width
      $error("ivtc_time_clock: both fields need at least one bit");
   end

   ivtc_op_e op;
   assign op = ivtc_decode(tick, load);

   if (SPLIT) begin : g_split
      logic [FRAC_W-1:0] frac_q;
      logic [SEC_W-1:0]  sec_q;
      logic              carry;

      assign carry = (frac_q == '1);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            frac_q <= '0;
            sec_q  <= '0;
         end else begin
            unique case (op)
               IVTC_LOAD: begin
                  frac_q <= load_val[FRAC_W-1:0];
                  sec_q  <= load_val[CLK_W-1:FRAC_W];
               end
               IVTC_STEP: begin
                  frac_q <= frac_q + FRAC_W'(1);
                  if (carry) sec_q <= sec_q + SEC_W'(1);
               end
               default: begin
                  frac_q <= frac_q;
                  sec_q  <= sec_q;
               end
            endcase
         end
      end

      assign cnt = {sec_q, frac_q};
   end else begin : g_flat
      logic [CLK_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else begin
            unique case (op)
               IVTC_LOAD: cnt_q <= load_val;
               IVTC_STEP: cnt_q <= cnt_q + CLK_W'(1);
               default:   cnt_q <= cnt_q;
            endcase
         end
      end

      assign cnt = cnt_q;
   end

   assert_count_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> (cnt == CLK_W'($past(cnt) + CLK_W'(1))));
   assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == '1) |=> (cnt == '0));
   assert_load_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/ivtc_word.sv
module ivtc_word
   import ivtc_pkg::*;
#(
   parameter int unsigned WORD_W  = IVTC_WORD_W,
   parameter int unsigned TMR_W   = IVTC_TMR_W,
   parameter int unsigned CLK_LSB = IVTC_CLK_LSB,
   parameter int unsigned FRAC_W  = IVTC_FRAC_W,
   parameter int unsigned SEC_W   = IVTC_SEC_W,
   parameter bit          SPLIT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              ind_clr,
   output logic [WORD_W-1:0] word_out,
   output logic              time_sig
);
   localparam int unsigned CLK_W = FRAC_W + SEC_W;
   localparam int unsigned GAP_W = CLK_LSB - TMR_W;

   if (TMR_W > CLK_LSB) begin : g_bad_overlap
      $error("ivtc_word: timer field overlaps clock field");
   end
   if (CLK_LSB + CLK_W != WORD_W) begin : g_bad_fit
      $error("ivtc_word: clock field must end at the word MSB");
   end

   logic [TMR_W-1:0] tmr_cnt;
   logic [CLK_W-1:0] clk_cnt;

   ivtc_interval_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (wr_en),
      .load_val (wr_data[TMR_W-1:0]),
      .clr      (ind_clr),
      .cnt      (tmr_cnt),
      .ind      (time_sig)
   );

   ivtc_time_clock #(.FRAC_W(FRAC_W), .SEC_W(SEC_W), .SPLIT(SPLIT)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (wr_en),
      .load_val (wr_data[WORD_W-1:CLK_LSB]),
      .cnt      (clk_cnt)
   );

   if (GAP_W > 0) begin : g_gap
      assign word_out = {clk_cnt, {GAP_W{1'b0}}, tmr_cnt};
   end else begin : g_nogap
      assign word_out = {clk_cnt, tmr_cnt};
   end

   assert_gap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (word_out[CLK_LSB-1:0] >> TMR_W) == '0);
   assert_write_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (word_out[WORD_W-1:CLK_LSB] == $past(wr_data[WORD_W-1:CLK_LSB])
                 && word_out[TMR_W-1:0] == $past(wr_data[TMR_W-1:0])));
   assert_reset_state_R2: assert property (@(posedge clk)
      !rst_n |=> (word_out == '0 && !time_sig));
endmodule

// File: tb/ivtc_word_tb_top.sv
module ivtc_word_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic        ind_clr = 1'b0;
   logic [63:0] word_out;
   logic        time_sig;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   ivtc_word dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_data(wr_data), .ind_clr(ind_clr),
      .word_out(word_out), .time_sig(time_sig)
   );

   function automatic logic [63:0] mk(input logic [35:0] c, input logic [18:0] t);
      return {c, 9'h000, t};
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // called at a negedge; applies inputs for one posedge, returns at next negedge
   task automatic cyc(input logic t, input logic w, input logic [63:0] d, input logic c);
      tick = t; wr_en = w; wr_data = d; ind_clr = c;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0; wr_data = '0; ind_clr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R2 word", word_out, 64'h0);
      chk("R2 flag", {63'h0, time_sig}, 64'h0);
   endtask

   task automatic t_load_layout;
      cyc(0, 1, {36'h123456789, 9'h1FF, 19'h45678}, 0);
      chk("R10 load", word_out, mk(36'h123456789, 19'h45678));
      cyc(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      chk("R1 gap bits", word_out, 64'hFFFF_FFFF_F007_FFFF);
   endtask

   task automatic t_count;
      cyc(0, 1, mk(36'h123456789, 19'h45678), 0);
      for (int i = 0; i < 3; i++) cyc(1, 0, '0, 0);
      chk("R3 R8 three ticks", word_out, mk(36'h12345678C, 19'h45675));
      cyc(0, 0, '0, 0);
      cyc(0, 0, '0, 0);
      chk("R3 idle hold", word_out, mk(36'h12345678C, 19'h45675));
   endtask

   task automatic t_zero;
      cyc(0, 1, mk(36'h0, 19'h2), 0);
      cyc(1, 0, '0, 0);
      chk("R5 before zero", {time_sig, word_out[62:0]}, {1'b0, mk(36'h1, 19'h1)}[63:0]);
      cyc(1, 0, '0, 0);
      chk("R5 reach zero timer", word_out, mk(36'h2, 19'h0));
      chk("R5 flag", {63'h0, time_sig}, 64'h1);
      for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0);
      chk("R6 sticky", {63'h0, time_sig}, 64'h1);
      cyc(1, 0, '0, 0);
      chk("R4 wrap", word_out, mk(36'h3, 19'h7FFFF));
      cyc(0, 0, '0, 1);
      chk("R6 clear", {63'h0, time_sig}, 64'h0);
      cyc(1, 0, '0, 0);
      chk("R7 no set after wrap", {63'h0, time_sig}, 64'h0);
      chk("R3 after wrap", word_out, mk(36'h4, 19'h7FFFE));
   endtask

   task automatic t_load_zero;
      cyc(0, 1, mk(36'h0, 19'h0), 0);
      cyc(0, 0, '0, 0);
      chk("R7 load zero", {63'h0, time_sig}, 64'h0);
      cyc(1, 0, '0, 0);
      chk("R7 wrap from loaded zero", {time_sig, word_out[62:0]}, {1'b0, mk(36'h1, 19'h7FFFF)}[63:0]);
   endtask

   task automatic t_set_vs_clear;
      cyc(0, 1, mk(36'h0, 19'h1), 0);
      cyc(1, 0, '0, 1);
      chk("R6 set beats clear", {63'h0, time_sig}, 64'h1);
      cyc(0, 0, '0, 1);
      chk("R6 clear next edge", {63'h0, time_sig}, 64'h0);
   endtask

   task automatic t_carry;
      cyc(0, 1, mk(36'h17FF, 19'h10), 0);
      cyc(1, 0, '0, 0);
      chk("R8 seconds", {38'h0, word_out[63:38]}, 64'd6);
      chk("R8 fraction", {54'h0, word_out[37:28]}, 64'd0);
   endtask

   task automatic t_clock_wrap;
      cyc(0, 1, mk(36'hF_FFFF_FFFF, 19'h5), 0);
      cyc(1, 0, '0, 0);
      chk("R9 clock wrap", word_out, mk(36'h0, 19'h4));
   endtask

   task automatic t_collide;
      cyc(0, 1, mk(36'h10, 19'h1), 0);
      cyc(1, 1, mk(36'h50, 19'h100), 0);
      chk("R11 write wins", word_out, mk(36'h50, 19'h100));
      chk("R11 no flag", {63'h0, time_sig}, 64'h0);
      cyc(0, 0, '0, 0);
      chk("R11 settled", word_out, mk(36'h50, 19'h100));
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_layout();
      t_count();
      t_zero();
      t_load_zero();
      t_set_vs_clear();
      t_carry();
      t_clock_wrap();
      t_collide();
      finish_run();
   end
endmodule